// File: doc/BRIEF.md
# Bridge-Steered PWM Output Stage

This block turns one pulse-width-modulated signal into the drive for four output pins, named A, B, C and D. An external free-running period timer supplies its count and a one-cycle pulse on the last count of each period. The block compares that count with a 10-bit duty value, which arrives as an 8-bit upper part and a 2-bit lower part. While the count is below the duty value the modulated signal is active.

A 2-bit bridge selection steers the modulated signal to the pins. It can drive a single pin, a complementary pair with a dead-band gap, or a four-pin bridge in either forward or reverse direction. A 2-bit polarity code sets the active level separately for the A/C pair and the B/D pair. Each pin has an ownership flag that tells the surrounding pad logic whether the PWM drives that pin or whether the pin is free for general use.

The duty value, the bridge selection and the polarity are shadowed. They take effect only at a period boundary, so a period in progress is never cut short or stretched. The dead-band count is read live, every clock.

Top module: `pwm_steer`

## Requirements
- R1: While reset is asserted, and before the first period boundary, `pin_own` is 4'b0001 and `pin_lvl` is 4'b0000. This matches single-pin mode, all pins active-high, and duty 0.
- R2: The duty value is `{duty_hi, duty_lo}`, with `duty_lo` as the two least significant bits. The modulated signal is active while `tmr_cnt` is below the duty value. Duty 0 is never active. A duty above the last count is active for the whole period. The pins are registered, and after a rising clock edge they reflect the `tmr_cnt` sampled at that edge.
- R3: `duty_hi`, `duty_lo`, `cfg_sel` and `pol_sel` are captured only at an edge where `period_hit` is 1. They apply from the next timer count on. Changes at any other time have no effect on the pins until the next boundary.
- R4: Bridge code 2'b00 (single): pin A carries the modulated signal. B, C and D are inactive, and `pin_own` = 4'b0001.
- R5: Bridge code 2'b01 (forward): pin D carries the modulated signal and pin A is held active. B and C are inactive, and `pin_own` = 4'b1111.
- R6: Bridge code 2'b10 (half bridge): pin A carries the modulated signal and pin B carries its complement. C and D are inactive, and `pin_own` = 4'b0011.
- R7: Bridge code 2'b11 (reverse): pin B carries the modulated signal and pin C is held active. A and D are inactive, and `pin_own` = 4'b1111.
- R8: Bit positions are A=0, B=1, C=2 and D=3 in both `pin_lvl` and `pin_own`. `pol_sel[1]` = 1 makes A and C active-low. `pol_sel[0]` = 1 makes B and D active-low. A pin at its inactive level shows the inverse of its active level.
- R9: A pin whose `pin_own` bit is 0 shows its inactive level.
- R10: In half-bridge mode, each change of pin A or pin B to its active level is delayed by `dead_cnt` clocks (0 to 127), and each change to its inactive level happens at once. A and B are never active together. In the other modes no delay applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_cnt | input | 10 | Current count of the external period timer |
| period_hit | input | 1 | One-cycle pulse on the last count of a period |
| duty_hi | input | 8 | Upper eight duty bits |
| duty_lo | input | 2 | Lower two duty bits |
| cfg_sel | input | 2 | Bridge steering code |
| pol_sel | input | 2 | Polarity code for the A/C and B/D pairs |
| dead_cnt | input | 7 | Dead-band delay in clocks for half-bridge mode |
| pin_lvl | output | 4 | Pin levels, A in bit 0 |
| pin_own | output | 4 | 1 where the PWM owns the pin |

## Verification
A shadow register holding a wrong duty value shows up within one period as a pin edge at the wrong timer count. A wrong steering or ownership decode shows up at the very next boundary as a wrong `pin_own` pattern, or as a held pin at the wrong level. A dead-band counter that fails to clear or saturate shows up one half-period later: a rising edge arrives at a count other than `dead_cnt` past the duty match, or the two half-bridge pins overlap. Because the pins are registered, every fault appears one clock after the timer count that causes it.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  localparam int PIN_CNT = 4;
  localparam int PIN_A   = 0;
  localparam int PIN_B   = 1;
  localparam int PIN_C   = 2;
  localparam int PIN_D   = 3;

  typedef enum logic [1:0] {
    CFG_SINGLE = 2'b00,
    CFG_FWD    = 2'b01,
    CFG_HALF   = 2'b10,
    CFG_REV    = 2'b11
  } bridge_cfg_e;

  // Active-sense value of every pin for a given bridge code and modulated level.
  function automatic logic [PIN_CNT-1:0] steer_act(input bridge_cfg_e cfg, input logic mod);
    logic [PIN_CNT-1:0] v;
    v = '0;
    case (cfg)
      CFG_SINGLE: v[PIN_A] = mod;
      CFG_FWD: begin
        v[PIN_A] = 1'b1;
        v[PIN_D] = mod;
      end
      CFG_HALF: begin
        v[PIN_A] = mod;
        v[PIN_B] = ~mod;
      end
      CFG_REV: begin
        v[PIN_B] = mod;
        v[PIN_C] = 1'b1;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  // Pins claimed by the PWM for a given bridge code.
  function automatic logic [PIN_CNT-1:0] own_mask(input bridge_cfg_e cfg);
    logic [PIN_CNT-1:0] v;
    case (cfg)
      CFG_SINGLE: v = 4'b0001;
      CFG_HALF:   v = 4'b0011;
      default:    v = 4'b1111;
    endcase
    return v;
  endfunction

  // Per-pin inversion: pol[1] covers A/C, pol[0] covers B/D.
  function automatic logic [PIN_CNT-1:0] inv_mask(input logic [1:0] pol);
    logic [PIN_CNT-1:0] v;
    v[PIN_A] = pol[1];
    v[PIN_C] = pol[1];
    v[PIN_B] = pol[0];
    v[PIN_D] = pol[0];
    return v;
  endfunction

endpackage

// File: rtl/pwm_steer_shadow.sv
module pwm_steer_shadow
  import pwm_steer_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_hit,
  input  logic [DUTY_W-1:0] duty_in,
  input  bridge_cfg_e       cfg_in,
  input  logic [1:0]        pol_in,
  output logic [DUTY_W-1:0] duty_q,
  output bridge_cfg_e       cfg_q,
  output logic [1:0]        pol_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      cfg_q  <= CFG_SINGLE;
      pol_q  <= 2'b00;
    end else if (period_hit) begin
      duty_q <= duty_in;
      cfg_q  <= cfg_in;
      pol_q  <= pol_in;
    end
  end

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_hit |=> ($stable(duty_q) && $stable(cfg_q) && $stable(pol_q)));

endmodule

// File: rtl/pwm_steer_cmp.sv
module pwm_steer_cmp #(
  parameter int DUTY_W = 10
) (
  input  logic [DUTY_W-1:0] tmr,
  input  logic [DUTY_W-1:0] duty,
  output logic              mod_on
);

  function automatic logic duty_active(input logic [DUTY_W-1:0] t, input logic [DUTY_W-1:0] d);
    return t < d;
  endfunction

  assign mod_on = duty_active(tmr, duty);

endmodule

// File: rtl/pwm_steer_db.sv
module pwm_steer_db #(
  parameter int DB_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want,
  input  logic [DB_W-1:0] dead,
  output logic            out_q
);

  logic [DB_W-1:0] cnt_q;
  logic            rise_evt;

  assign rise_evt = want && !out_q && (cnt_q >= dead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (!want) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (rise_evt) begin
      out_q <= 1'b1;
    end else if (!out_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  db_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !want |=> !out_q);

  // R10
  db_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(want));

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_steer_pkg::*;
#(
  parameter int DUTY_HI_W = 8,
  parameter int DUTY_LO_W = 2,
  parameter int DB_W      = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [DUTY_HI_W+DUTY_LO_W-1:0] tmr_cnt,
  input  logic                           period_hit,
  input  logic [DUTY_HI_W-1:0]           duty_hi,
  input  logic [DUTY_LO_W-1:0]           duty_lo,
  input  logic [1:0]                     cfg_sel,
  input  logic [1:0]                     pol_sel,
  input  logic [DB_W-1:0]                dead_cnt,
  output logic [3:0]                     pin_lvl,
  output logic [3:0]                     pin_own
);

  localparam int DUTY_W  = DUTY_HI_W + DUTY_LO_W;
  localparam int PAIR_DB = 2;

  logic [DUTY_W-1:0]  duty_q;
  bridge_cfg_e        cfg_q;
  logic [1:0]         pol_q;
  logic               mod_on;
  logic [PIN_CNT-1:0] act_n;
  logic [PIN_CNT-1:0] act_q;
  logic [DB_W-1:0]    dead_eff;
  logic [PIN_CNT-1:0] own_q;
  logic [1:0]         pol_o_q;
  bridge_cfg_e        cfg_o_q;
  logic [PIN_CNT-1:0] inv_o;

  pwm_steer_shadow #(.DUTY_W(DUTY_W)) shadow_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_hit (period_hit),
    .duty_in    ({duty_hi, duty_lo}),
    .cfg_in     (bridge_cfg_e'(cfg_sel)),
    .pol_in     (pol_sel),
    .duty_q     (duty_q),
    .cfg_q      (cfg_q),
    .pol_q      (pol_q)
  );

  pwm_steer_cmp #(.DUTY_W(DUTY_W)) cmp_i (
    .tmr    (tmr_cnt),
    .duty   (duty_q),
    .mod_on (mod_on)
  );

  assign act_n    = steer_act(cfg_q, mod_on);
  assign dead_eff = (cfg_q == CFG_HALF) ? dead_cnt : '0;

  for (genvar g = 0; g < PAIR_DB; g++) begin : g_db
    pwm_steer_db #(.DB_W(DB_W)) db_i (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (act_n[g]),
      .dead  (dead_eff),
      .out_q (act_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q[PIN_CNT-1:PAIR_DB] <= '0;
      own_q                    <= own_mask(CFG_SINGLE);
      pol_o_q                  <= 2'b00;
      cfg_o_q                  <= CFG_SINGLE;
    end else begin
      act_q[PIN_CNT-1:PAIR_DB] <= act_n[PIN_CNT-1:PAIR_DB];
      own_q                    <= own_mask(cfg_q);
      pol_o_q                  <= pol_q;
      cfg_o_q                  <= cfg_q;
    end
  end

  assign inv_o   = inv_mask(pol_o_q);
  assign pin_lvl = act_q ^ inv_o;
  assign pin_own = own_q;

  // R9
  released_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_lvl & ~pin_own) == (inv_o & ~pin_own)));

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o_q == CFG_HALF) |-> !(act_q[PIN_A] && act_q[PIN_B]));

  // R5
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o_q == CFG_FWD) |-> (act_q[PIN_A] && !act_q[PIN_B] && !act_q[PIN_C]));

  // R7
  rev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o_q == CFG_REV) |-> (act_q[PIN_C] && !act_q[PIN_A] && !act_q[PIN_D]));

  // R4
  own_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o_q == CFG_SINGLE) |-> (pin_own == 4'b0001));

endmodule

// File: tb/pwm_steer_tb.sv
module pwm_steer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PER        = 16;
  localparam int N_VEC      = 11;

  typedef struct packed {
    logic [1:0] cfg;
    logic [1:0] pol;
    logic [9:0] duty;
    logic [3:0] hi;
    logic [3:0] lo;
    logic [3:0] own;
  } vec_t;

  // Pin order {D,C,B,A}; hi = pins while modulated active, lo = while inactive.
  localparam vec_t VECS [0:N_VEC-1] = '{
    '{2'b00, 2'b00, 10'd5,    4'b0001, 4'b0000, 4'b0001}, // R4 single
    '{2'b00, 2'b11, 10'd5,    4'b1110, 4'b1111, 4'b0001}, // R8 all low
    '{2'b01, 2'b00, 10'd9,    4'b1001, 4'b0001, 4'b1111}, // R5 forward
    '{2'b01, 2'b01, 10'd9,    4'b0011, 4'b1011, 4'b1111}, // R8 B/D low
    '{2'b11, 2'b00, 10'd3,    4'b0110, 4'b0100, 4'b1111}, // R7 reverse
    '{2'b11, 2'b10, 10'd3,    4'b0011, 4'b0001, 4'b1111}, // R8 A/C low
    '{2'b10, 2'b00, 10'd8,    4'b0001, 4'b0010, 4'b0011}, // R6 half
    '{2'b10, 2'b11, 10'd8,    4'b1110, 4'b1101, 4'b0011}, // R6 R8
    '{2'b00, 2'b00, 10'd0,    4'b0001, 4'b0000, 4'b0001}, // R2 duty zero
    '{2'b00, 2'b00, 10'd1023, 4'b0001, 4'b0000, 4'b0001}, // R2 duty full
    '{2'b00, 2'b00, 10'd6,    4'b0001, 4'b0000, 4'b0001}  // R2 low bits
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] tmr_cnt;
  logic       period_hit;
  logic [7:0] duty_hi;
  logic [1:0] duty_lo;
  logic [1:0] cfg_sel;
  logic [1:0] pol_sel;
  logic [6:0] dead_cnt;
  logic [3:0] pin_lvl;
  logic [3:0] pin_own;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_steer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_cnt    (tmr_cnt),
    .period_hit (period_hit),
    .duty_hi    (duty_hi),
    .duty_lo    (duty_lo),
    .cfg_sel    (cfg_sel),
    .pol_sel    (pol_sel),
    .dead_cnt   (dead_cnt),
    .pin_lvl    (pin_lvl),
    .pin_own    (pin_own)
  );

  task automatic chk(input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic step(input int t);
    @(negedge clk);
    tmr_cnt    = 10'(t);
    period_hit = (t == PER-1);
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    for (int t = 0; t < PER; t++) step(t);
  endtask

  task automatic program_in(input logic [1:0] c, input logic [1:0] p,
                            input logic [9:0] d, input logic [6:0] db);
    cfg_sel  = c;
    pol_sel  = p;
    duty_hi  = d[9:2];
    duty_lo  = d[1:0];
    dead_cnt = db;
  endtask

  initial begin
    rst_n = 1'b0;
    tmr_cnt = '0;
    period_hit = 1'b0;
    program_in(2'b00, 2'b00, 10'd0, 7'd0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset own", pin_own, 4'b0001);
    chk("R1 reset lvl", pin_lvl, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    step(3);
    chk("R1 before boundary lvl", pin_lvl, 4'b0000);

    // Table: one settling period latches the entry, the next is checked.
    for (int i = 0; i < N_VEC; i++) begin
      program_in(VECS[i].cfg, VECS[i].pol, VECS[i].duty, 7'd0);
      settle();
      for (int t = 0; t < PER; t++) begin
        step(t);
        chk($sformatf("table[%0d] R2 t=%0d lvl", i, t), pin_lvl,
            (10'(t) < VECS[i].duty) ? VECS[i].hi : VECS[i].lo);
        chk($sformatf("table[%0d] R9 t=%0d own", i, t), pin_own, VECS[i].own);
      end
    end

    // R3: inputs changed inside a period are deferred to the boundary.
    program_in(2'b00, 2'b00, 10'd4, 7'd0);
    settle();
    program_in(2'b01, 2'b11, 10'd12, 7'd0);
    for (int t = 0; t < PER; t++) begin
      step(t);
      chk($sformatf("R3 deferred t=%0d lvl", t), pin_lvl, (t < 4) ? 4'b0001 : 4'b0000);
      chk($sformatf("R3 deferred t=%0d own", t), pin_own, 4'b0001);
    end
    for (int t = 0; t < PER; t++) begin
      step(t);
      chk($sformatf("R3 applied t=%0d lvl", t), pin_lvl, (t < 12) ? 4'b0110 : 4'b1110);
      chk($sformatf("R3 applied t=%0d own", t), pin_own, 4'b1111);
    end

    // R10: dead band of 3 clocks on each rising edge of A and B.
    program_in(2'b10, 2'b00, 10'd8, 7'd3);
    settle();
    settle();
    for (int t = 0; t < PER; t++) begin
      logic a_e, b_e;
      a_e = (t >= 3) && (t < 8);
      b_e = (t >= 11);
      step(t);
      chk($sformatf("R10 dead3 t=%0d lvl", t), pin_lvl, {2'b00, b_e, a_e});
    end

    // R10: dead band longer than either phase keeps both pins inactive.
    dead_cnt = 7'd20;
    settle();
    for (int t = 0; t < PER; t++) begin
      step(t);
      chk($sformatf("R10 dead20 t=%0d lvl", t), pin_lvl, 4'b0000);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule